// File: doc/BRIEF.md
# Link Controller Interrupt and Status Register

This block holds the interrupt status of a link-level controller. The receiver, transmitter, primitive logic and the bus master each report events as single-cycle pulses. Each pulse sets its own sticky status bit. Software reads the bits through a one-word host port and clears a bit by writing a one to it. A read-only summary flag is the OR of all status bits. An enable bit gates that flag onto an active-low interrupt pin.

The block also watches bus cycles. While the controller is bus master and has an address out, it waits for ready. If ready does not come in time, the block sets the memory-error bit. It then asks for the bus to be released and for the receiver and transmitter to be switched off.

When the missed-frame bit is set, the receiver is switched off. If a data link is up at that moment, the block also enters local busy and requests a receiver-not-ready response. When software later clears that bit, the block leaves local busy and requests a receiver-ready response. A stop primitive clears the whole register, just as reset does.

Top module: `lnk_irq_status`

## Requirements
- R1: Register layout: enable at bit 9, summary at bit 8, memory error at 7, missed frame at 6, receive overrun at 5, transmit underrun at 4, primitive at 3, transmit done at 2 and receive done at 1. Bit 0 and all bits above 9 read as zero.
- R2: The summary bit reads 1 exactly when at least one of bits 7..1 is set. Writes to bit 8 have no effect.
- R3: `irq_n` is low only when both the enable bit and the summary bit are 1. Otherwise it is high.
- R4: Writing 1 to bit 9 sets the enable bit and writing 0 clears it. While `stopped` is high, a write of 1 to bit 9 leaves the enable bit unchanged.
- R5: Each event input sets its status bit on the next clock edge. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: Reset, and `stop_prim` held for one cycle, clear every register bit and local busy. No response request is issued.
- R7: If an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R8: While `bus_master` and `addr_valid` are high, the block counts consecutive cycles without `bus_ready`. The memory-error bit is set after 256 such cycles and not after 255. Cycles in which the block is not bus master are never counted.
- R9: When the memory-error bit is set by a timeout, `bus_release`, `rx_off` and `tx_off` each pulse high for one cycle, visible together with the bit.
- R10: A missed-frame event pulses `rx_off`. If `link_up` is high, it also sets `local_busy` and pulses `rnr_req` for one cycle. If `link_up` is low, neither happens.
- R11: A software clear of the missed-frame bit while `local_busy` is high drops `local_busy` and pulses `rr_req` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_prim | input | 1 | Stop primitive; clears the register |
| stopped | input | 1 | Controller is in the stopped phase |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Host read data |
| ev_miss | input | 1 | Missed-frame event |
| ev_ror | input | 1 | Receive overrun event |
| ev_tur | input | 1 | Transmit underrun event |
| ev_pint | input | 1 | Primitive issued event |
| ev_tint | input | 1 | Transmit done event |
| ev_rint | input | 1 | Receive done event |
| bus_master | input | 1 | Controller owns the bus |
| addr_valid | input | 1 | Address is driven on the bus |
| bus_ready | input | 1 | Bus cycle ready |
| link_up | input | 1 | Data link established |
| irq_n | output | 1 | Active-low interrupt pin |
| bus_release | output | 1 | Pulse: release the bus |
| rx_off | output | 1 | Pulse: switch the receiver off |
| tx_off | output | 1 | Pulse: switch the transmitter off |
| local_busy | output | 1 | Local busy state |
| rnr_req | output | 1 | Pulse: request a receiver-not-ready response |
| rr_req | output | 1 | Pulse: request a receiver-ready response |

## Verification
The hardest case to reach is the exact edge of the ready timeout. It needs 255 and 256 uninterrupted waiting cycles, with the count broken by a ready pulse or by losing bus mastership. The bench holds the waiting condition for a computed number of cycles and samples the memory-error bit and the three shutdown pulses in the cycle after the last one.

The busy handshake is also hard to reach, because it depends on the order of events. The bench sets the missed-frame bit with the link up and with the link down, then clears it by a write. It checks that only the first of those paths produces both the receiver-not-ready and the receiver-ready pulses.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;
    localparam int REG_W   = 16;
    localparam int N_STS   = 7;   // status bits live at register bits 1..7
    localparam int B_INEA  = 9;
    localparam int B_INTR  = 8;
    localparam int B_MERR  = 7;
    localparam int B_MISS  = 6;
    // index into the status vector: register bit minus one
    localparam int S_MERR  = 6;
    localparam int S_MISS  = 5;

    typedef struct packed {
        logic             inea;
        logic [N_STS-1:0] sts;
        logic             bus_rel;
        logic             rx_off;
        logic             tx_off;
    } reg_state_t;
endpackage

// File: rtl/lnk_ready_watchdog.sv
module lnk_ready_watchdog #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_prim,
    input  logic bus_master,
    input  logic addr_valid,
    input  logic bus_ready,
    output logic expire
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } wd_t;

    wd_t  st_q, st_d;
    logic waiting;

    always_comb begin
        waiting = bus_master && addr_valid && !bus_ready;
        expire  = waiting && !st_q.fired && (st_q.cnt == LAST);
        st_d    = st_q;
        if (stop_prim || !waiting) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (expire) begin
            st_d.fired = 1'b1;
        end else if (!st_q.fired) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    a_r8_idle_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_master |-> !expire);
endmodule

// File: rtl/lnk_busy_tracker.sv
module lnk_busy_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_prim,
    input  logic miss_set,
    input  logic miss_clr,
    input  logic link_up,
    output logic local_busy,
    output logic rnr_req,
    output logic rr_req
);
    typedef struct packed {
        logic busy;
        logic rnr;
        logic rr;
    } bt_t;

    bt_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.rnr = 1'b0;
        st_d.rr  = 1'b0;
        if (stop_prim) begin
            st_d.busy = 1'b0;
        end else if (miss_set) begin
            if (link_up && !st_q.busy) begin
                st_d.busy = 1'b1;
                st_d.rnr  = 1'b1;
            end
        end else if (miss_clr && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.rr   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign local_busy = st_q.busy;
    assign rnr_req    = st_q.rnr;
    assign rr_req     = st_q.rr;

    a_r10_rnr_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rnr_req |-> local_busy);
    a_r11_rr_leaves_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rr_req |-> !local_busy);
    a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rnr_req && rr_req));
endmodule

// File: rtl/lnk_irq_status.sv
module lnk_irq_status
    import lnk_irq_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_prim,
    input  logic             stopped,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_miss,
    input  logic             ev_ror,
    input  logic             ev_tur,
    input  logic             ev_pint,
    input  logic             ev_tint,
    input  logic             ev_rint,
    input  logic             bus_master,
    input  logic             addr_valid,
    input  logic             bus_ready,
    input  logic             link_up,
    output logic             irq_n,
    output logic             bus_release,
    output logic             rx_off,
    output logic             tx_off,
    output logic             local_busy,
    output logic             rnr_req,
    output logic             rr_req
);
    reg_state_t       st_q, st_d;
    logic             expire;
    logic [N_STS-1:0] ev_vec;
    logic [N_STS-1:0] clr_vec;
    logic             intr;
    logic             miss_clr;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[REG_W-1:B_INEA+1], wr_data[B_INTR], wr_data[0]};

    lnk_ready_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_prim  (stop_prim),
        .bus_master (bus_master),
        .addr_valid (addr_valid),
        .bus_ready  (bus_ready),
        .expire     (expire)
    );

    always_comb begin
        ev_vec   = {expire, ev_miss, ev_ror, ev_tur, ev_pint, ev_tint, ev_rint};
        clr_vec  = wr_en ? wr_data[N_STS:1] : '0;
        miss_clr = clr_vec[S_MISS] && st_q.sts[S_MISS] && !ev_miss;

        st_d         = st_q;
        st_d.bus_rel = expire;
        st_d.tx_off  = expire;
        st_d.rx_off  = expire || ev_miss;
        for (int i = 0; i < N_STS; i++) begin
            st_d.sts[i] = ev_vec[i] || (st_q.sts[i] && !clr_vec[i]);
        end
        if (wr_en) begin
            if (!wr_data[B_INEA])  st_d.inea = 1'b0;
            else if (!stopped)     st_d.inea = 1'b1;
        end
        if (stop_prim) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lnk_busy_tracker u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_prim  (stop_prim),
        .miss_set   (ev_miss),
        .miss_clr   (miss_clr),
        .link_up    (link_up),
        .local_busy (local_busy),
        .rnr_req    (rnr_req),
        .rr_req     (rr_req)
    );

    always_comb begin
        intr                = |st_q.sts;
        rd_data             = '0;
        rd_data[N_STS:1]    = st_q.sts;
        rd_data[B_INTR]     = intr;
        rd_data[B_INEA]     = st_q.inea;
        irq_n               = !(st_q.inea && intr);
    end

    assign bus_release = st_q.bus_rel;
    assign rx_off      = st_q.rx_off;
    assign tx_off      = st_q.tx_off;

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_prim |=> (rd_data == '0));
    a_r4_no_enable_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !rd_data[B_INEA]) |=> !rd_data[B_INEA]);
    a_r7_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_miss && !stop_prim) |=> rd_data[B_MISS]);
    a_r9_merr_with_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> (rd_data[B_MERR] && tx_off && rx_off));
    a_r3_pin_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (rd_data[B_INEA] && rd_data[B_INTR]));
endmodule

// File: tb/lnk_irq_status_test.sv
module lnk_irq_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_prim = 0, stopped = 0, wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic ev_miss = 0, ev_ror = 0, ev_tur = 0, ev_pint = 0, ev_tint = 0, ev_rint = 0;
    logic bus_master = 0, addr_valid = 0, bus_ready = 0, link_up = 0;
    logic irq_n, bus_release, rx_off, tx_off, local_busy, rnr_req, rr_req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    lnk_irq_status uut (
        .clk(clk), .rst_n(rst_n), .stop_prim(stop_prim), .stopped(stopped),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_miss(ev_miss), .ev_ror(ev_ror), .ev_tur(ev_tur), .ev_pint(ev_pint),
        .ev_tint(ev_tint), .ev_rint(ev_rint), .bus_master(bus_master),
        .addr_valid(addr_valid), .bus_ready(bus_ready), .link_up(link_up),
        .irq_n(irq_n), .bus_release(bus_release), .rx_off(rx_off), .tx_off(tx_off),
        .local_busy(local_busy), .rnr_req(rnr_req), .rr_req(rr_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ev(input int idx);   // idx = register bit 1..6
        case (idx)
            1: ev_rint = 1; 2: ev_tint = 1; 3: ev_pint = 1;
            4: ev_tur  = 1; 5: ev_ror  = 1; 6: ev_miss = 1;
            default: ;
        endcase
        step();
        {ev_rint, ev_tint, ev_pint, ev_tur, ev_ror, ev_miss} = '0;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d;
        step();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic stop_pulse();
        stop_prim = 1; step(); stop_prim = 0;
    endtask

    function automatic logic [15:0] expect_reg(input logic inea, input logic [6:0] s);
        logic [15:0] r;
        r = '0;
        r[7:1] = s;
        r[8] = |s;
        r[9] = inea;
        return r;
    endfunction

    task automatic wait_run(input int n);
        bus_master = 1; addr_valid = 1; bus_ready = 0;
        repeat (n) step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R6 reset reg", rd_data, 16'h0);
        chk("R6 reset pin", irq_n, 1);
        chk("R6 reset busy", local_busy, 0);
        rst_n = 1;
        step();

        // R5/R2/R3/R1 sweep over every hardware-set bit and both enable values
        for (int en = 0; en < 2; en++) begin
            for (int b = 1; b <= 6; b++) begin
                wr(en ? 16'h0200 : 16'h0000);
                pulse_ev(b);
                chk("R5 set", rd_data, expect_reg(en[0], 7'(1 << (b - 1))));
                chk("R3 pin", irq_n, en ? 0 : 1);
                wr(16'hFC01 | (en ? 16'h0200 : 16'h0000) | 16'h0100); // write 0 to status bits
                chk("R5 zero no effect", rd_data, expect_reg(en[0], 7'(1 << (b - 1))));
                wr(16'(1 << b) | (en ? 16'h0200 : 16'h0000));
                chk("R2 summary drops", rd_data, expect_reg(en[0], 7'h0));
                chk("R3 pin idle", irq_n, 1);
            end
        end

        // R1: all status bits at once, upper and bit 0 stay zero
        wr(16'hFFFF);
        ev_rint = 1; ev_tint = 1; ev_pint = 1; ev_tur = 1; ev_ror = 1; ev_miss = 1;
        step();
        {ev_rint, ev_tint, ev_pint, ev_tur, ev_ror, ev_miss} = '0;
        chk("R1 layout", rd_data, 16'h037E);
        wr(16'h01FE);   // clears statuses, writes 0 to enable
        chk("R1 clear all", rd_data, 16'h0000);

        // R7: set wins over clear in the same cycle
        ev_pint = 1; wr_en = 1; wr_data = 16'h0008;
        step();
        ev_pint = 0; wr_en = 0; wr_data = '0;
        chk("R7 set wins", rd_data[3], 1);
        wr(16'h0008);

        // R4: enable blocked while stopped
        stopped = 1;
        wr(16'h0200);
        chk("R4 blocked", rd_data[9], 0);
        stopped = 0;
        wr(16'h0200);
        chk("R4 set", rd_data[9], 1);
        wr(16'h0000);
        chk("R4 clear", rd_data[9], 0);
        wr(16'h0200);
        stopped = 1;
        wr(16'h0000);
        chk("R4 clear while stopped", rd_data[9], 0);
        stopped = 0;

        // R8/R9: timeout boundaries
        wait_run(255);
        bus_ready = 1; step(); bus_master = 0; addr_valid = 0; bus_ready = 0;
        chk("R8 255 no merr", rd_data[7], 0);
        wait_run(200);
        bus_master = 0; step();
        wait_run(100);
        bus_master = 0; addr_valid = 0; step();
        chk("R8 non-master break", rd_data[7], 0);
        wait_run(256);
        chk("R8 256 merr", rd_data[7], 1);
        chk("R9 release", bus_release, 1);
        chk("R9 rx off", rx_off, 1);
        chk("R9 tx off", tx_off, 1);
        step();
        chk("R9 single pulse", {bus_release, tx_off}, 2'b00);
        bus_master = 0; addr_valid = 0;
        wr(16'h0080);
        chk("R5 merr cleared", rd_data, 16'h0);

        // R10/R11: busy handshake
        link_up = 1;
        pulse_ev(6);
        chk("R10 rnr", {rnr_req, local_busy, rx_off}, 3'b111);
        step();
        chk("R10 rnr one cycle", rnr_req, 0);
        wr(16'h0040);
        chk("R11 rr", {rr_req, local_busy}, 2'b10);
        step();
        chk("R11 rr one cycle", rr_req, 0);
        link_up = 0;
        pulse_ev(6);
        chk("R10 no link", {rnr_req, local_busy, rx_off}, 3'b001);
        wr(16'h0040);
        chk("R11 no rr when idle", {rr_req, rd_data[6]}, 2'b00);

        // R6: stop primitive clears all
        link_up = 1;
        wr(16'h0200);
        pulse_ev(6);
        pulse_ev(2);
        stop_pulse();
        chk("R6 stop reg", rd_data, 16'h0);
        chk("R6 stop busy", {local_busy, rr_req, irq_n}, 3'b001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule